// File: doc/BRIEF.md
# Sleep Control Register with Sleep-Request Decode

This block holds a 16-bit power-management control word behind a simple register port. Software reads the stored word back at any time. A write that sets the sleep-enable bit starts a sleep request. The block decodes the 3-bit sleep-type field carried in that same write. It then raises a one-cycle request pulse toward the power sequencer: soft power-off, suspend, or hibernate. A hibernate request raises the power-off pulse together with a hibernate notification.

Bit 0 of the word is the interrupt-routing enable. Two side inputs from chipset logic can set or clear it independently of the register port. The sleep-type code that means hibernate comes from a static configuration input, so one design can serve platforms that number their sleep states differently. Carrying out the power transitions is left to the logic that consumes the pulses.

Top module: `slpctl_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the read data is 0x0000 and all three request outputs are low.
- R2: A full write (wrEn high, wrByteEn = 2'b11) stores wrData with bit 13 forced to 0. rdData shows the stored value from the cycle after the write.
- R3: A write whose wrByteEn is not 2'b11 is dropped. It changes neither the stored word nor any request output.
- R4: A full write with bit 13 set and bits 12:10 equal to 0 pulses powerOffReq high for exactly the one cycle after the write.
- R5: A full write with bit 13 set and bits 12:10 equal to 1 pulses suspendReq high for exactly the one cycle after the write.
- R6: A full write with bit 13 set whose bits 12:10 are 2 or more and equal hibType pulses hibernateNote and powerOffReq together for the one cycle after the write.
- R7: A full write with bit 13 set whose bits 12:10 are 2 or more and differ from hibType produces no pulse. The rest of the word is still stored.
- R8: A full write with bit 13 clear only updates the stored word and produces no pulse, whatever its bits 12:10 hold.
- R9: sciSetIn sets bit 0 of the stored word. sciClrIn clears it when sciSetIn is low. When both are high, bit 0 is set.
- R10: When a full write and an SCI input fall in the same cycle, bit 0 follows the SCI input and bits 15:1 follow the write.
- R11: A hibType of 0 or 1 does not change the fixed meaning of types 0 and 1. Such writes never raise hibernateNote.
- R12: Back-to-back sleep writes give a pulse in each following cycle, one per accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrByteEn | input | 2 | Byte lanes of the write; only 2'b11 is accepted |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Stored control word |
| sciSetIn | input | 1 | Sets the interrupt-routing enable bit 0 |
| sciClrIn | input | 1 | Clears bit 0 when sciSetIn is low |
| hibType | input | 3 | Sleep-type code that selects hibernate |
| powerOffReq | output | 1 | One-cycle soft power-off request |
| suspendReq | output | 1 | One-cycle suspend request |
| hibernateNote | output | 1 | One-cycle hibernate notification, paired with powerOffReq |

## Verification
The hardest case to reach from the ports is a collision on bit 0. A register write and an SCI input land in the same cycle, sometimes together with a sleep request. Bit 0 must then follow the SCI input while the upper bits and the pulse follow the write. The stimulus reaches this by driving both in one cycle, with written bit-0 values that disagree with the SCI input. A second set of cases reprograms hibType onto 0 and 1, and then onto a value that a write later misses. This separates the fixed codes from the programmable one.

// File: rtl/slpctl_pkg.sv
package slpctl_pkg;
  localparam int SLP_EN_BIT = 13;
  localparam int TYPE_LSB   = 10;
  localparam int SCI_BIT    = 0;

  typedef struct packed {
    logic storeWr;
    logic sciSet;
    logic sciClr;
  } ctlStrobes_t;
endpackage

// File: rtl/slpctl_ctrl.sv
module slpctl_ctrl
  import slpctl_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int TYPE_W = 3,
  parameter int BE_W   = REG_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [BE_W-1:0]   wrByteEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic              sciSetIn,
  input  logic              sciClrIn,
  input  logic [TYPE_W-1:0] hibType,
  output ctlStrobes_t       strobes,
  output logic              powerOffReq,
  output logic              suspendReq,
  output logic              hibernateNote
);
  localparam logic [TYPE_W-1:0] TYPE_OFF  = '0;
  localparam logic [TYPE_W-1:0] TYPE_SUSP = TYPE_W'(1);

  logic              accepted;
  logic              sleepReq;
  logic [TYPE_W-1:0] slpType;
  logic              isProg;
  logic              offNext, suspNext, hibNext;

  assign accepted = wrEn && (&wrByteEn);
  assign sleepReq = accepted && wrData[SLP_EN_BIT];
  assign slpType  = wrData[TYPE_LSB +: TYPE_W];
  assign isProg   = (slpType != TYPE_OFF) && (slpType != TYPE_SUSP)
                    && (slpType == hibType);

  always_comb begin
    strobes.storeWr = accepted;
    strobes.sciSet  = sciSetIn;
    strobes.sciClr  = sciClrIn && !sciSetIn;
    offNext  = sleepReq && ((slpType == TYPE_OFF) || isProg);
    suspNext = sleepReq && (slpType == TYPE_SUSP);
    hibNext  = sleepReq && isProg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      powerOffReq   <= 1'b0;
      suspendReq    <= 1'b0;
      hibernateNote <= 1'b0;
    end else begin
      powerOffReq   <= offNext;
      suspendReq    <= suspNext;
      hibernateNote <= hibNext;
    end
  end

  // R4: a power-off pulse only follows an accepted sleep write
  a_r4_off_cause: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |-> $past(wrEn && (&wrByteEn) && wrData[SLP_EN_BIT]));
  // R6: a hibernate notification always comes with a power-off request
  a_r6_hib_with_off: assert property (@(posedge clk) disable iff (!rstN)
    hibernateNote |-> powerOffReq);
  // R5: suspend and power-off never pulse in the same cycle
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(powerOffReq && suspendReq));
  // R8: a write without the sleep bit gives no pulse next cycle
  a_r8_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[SLP_EN_BIT]) |=> !(powerOffReq || suspendReq || hibernateNote));
endmodule

// File: rtl/slpctl_datapath.sv
module slpctl_datapath
  import slpctl_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] ctlQ
);
  localparam logic [REG_W-1:0] STORE_MASK = ~(REG_W'(1) << SLP_EN_BIT);

  logic [REG_W-1:0] ctlNext;

  always_comb begin
    ctlNext = ctlQ;
    if (strobes.storeWr) ctlNext = wrData & STORE_MASK;
    if (strobes.sciSet)      ctlNext[SCI_BIT] = 1'b1;
    else if (strobes.sciClr) ctlNext[SCI_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctlQ <= '0;
    else       ctlQ <= ctlNext;
  end

  // R9: the set strobe wins on bit 0
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sciSet |=> ctlQ[SCI_BIT]);
  // R9: the clear strobe alone clears bit 0
  a_r9_clr: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sciClr && !strobes.sciSet) |=> !ctlQ[SCI_BIT]);
  // R2: the sleep-enable bit is never seen in the stored word
  a_r2_slp_hidden: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeWr |=> !ctlQ[SLP_EN_BIT]);
endmodule

// File: rtl/slpctl_top.sv
module slpctl_top
  import slpctl_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int TYPE_W = 3,
  parameter int BE_W   = REG_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [BE_W-1:0]   wrByteEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic              sciSetIn,
  input  logic              sciClrIn,
  input  logic [TYPE_W-1:0] hibType,
  output logic              powerOffReq,
  output logic              suspendReq,
  output logic              hibernateNote
);
  ctlStrobes_t strobes;

  slpctl_ctrl #(.REG_W(REG_W), .TYPE_W(TYPE_W), .BE_W(BE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrByteEn(wrByteEn),
    .wrData(wrData), .sciSetIn(sciSetIn), .sciClrIn(sciClrIn),
    .hibType(hibType), .strobes(strobes), .powerOffReq(powerOffReq),
    .suspendReq(suspendReq), .hibernateNote(hibernateNote)
  );

  slpctl_datapath #(.REG_W(REG_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .ctlQ(rdData)
  );

  // R3: a partial write with no SCI activity leaves everything unchanged
  a_r3_partial_drop: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !(&wrByteEn) && !sciSetIn && !sciClrIn)
      |=> ($stable(rdData) && !powerOffReq && !suspendReq));
endmodule

// File: tb/slpctl_top_tb_top.sv
module slpctl_top_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] rd;
    logic        off;
    logic        sus;
    logic        hib;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrByteEn = 2'b00;
  logic [15:0] wrData = '0;
  logic        sciSetIn = 1'b0;
  logic        sciClrIn = 1'b0;
  logic [2:0]  hibType = 3'd5;
  logic [15:0] rdData;
  logic        powerOffReq, suspendReq, hibernateNote;

  int checks = 0;
  int failures = 0;
  logic [15:0] modelReg = '0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  slpctl_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrByteEn(wrByteEn), .wrData(wrData),
    .rdData(rdData), .sciSetIn(sciSetIn), .sciClrIn(sciClrIn), .hibType(hibType),
    .powerOffReq(powerOffReq), .suspendReq(suspendReq), .hibernateNote(hibernateNote)
  );

  task automatic compare(input expItem_t e);
    checks++;
    if (rdData !== e.rd || powerOffReq !== e.off || suspendReq !== e.sus
        || hibernateNote !== e.hib) begin
      failures++;
      $display("FAIL %s: actual rd=%h off=%b sus=%b hib=%b expected rd=%h off=%b sus=%b hib=%b",
               e.tag, rdData, powerOffReq, suspendReq, hibernateNote,
               e.rd, e.off, e.sus, e.hib);
    end
  endtask

  // Driver: one operation per clock, expected result pushed to the scoreboard
  task automatic op(input logic en, input logic [1:0] be, input logic [15:0] d,
                    input logic set, input logic clr, input string tag);
    expItem_t e;
    logic acc, slp;
    logic [2:0] ty;
    @(negedge clk);
    wrEn = en; wrByteEn = be; wrData = d; sciSetIn = set; sciClrIn = clr;
    acc = en && (be == 2'b11);
    if (acc) modelReg = d & 16'hDFFF;
    if (set) modelReg[0] = 1'b1;
    else if (clr) modelReg[0] = 1'b0;
    slp = acc && d[13];
    ty  = d[12:10];
    e.rd  = modelReg;
    e.sus = slp && (ty == 3'd1);
    e.hib = slp && (ty > 3'd1) && (ty == hibType);
    e.off = slp && ((ty == 3'd0) || e.hib);
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(input string tag);
    op(1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compares each cycle's outputs after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog: actual running expected finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    expItem_t r;
    repeat (3) @(posedge clk);
    #1;
    r.rd = 16'h0; r.off = 0; r.sus = 0; r.hib = 0; r.tag = "R1 reset";
    compare(r);
    @(negedge clk); rstN = 1'b1;
    idle("R1 after reset");
    // R8: no sleep bit, any type field
    op(1, 2'b11, 16'h0000, 0, 0, "R8 type0 no sleep bit");
    op(1, 2'b11, 16'h1C05, 0, 0, "R8 type7 no sleep bit");
    // R2/R7: all ones, type 7 is not the hibernate code 5
    op(1, 2'b11, 16'hFFFF, 0, 0, "R2 R7 store masks bit13");
    // R4 power-off, then single-cycle check
    op(1, 2'b11, 16'h2000, 0, 0, "R4 power-off pulse");
    idle("R4 pulse is one cycle");
    // R5 suspend
    op(1, 2'b11, 16'h2401, 0, 0, "R5 suspend pulse");
    idle("R5 pulse is one cycle");
    // R6 hibernate (type 5)
    op(1, 2'b11, 16'h3400, 0, 0, "R6 hibernate plus power-off");
    idle("R6 pulse is one cycle");
    // R7 type 6 ignored
    op(1, 2'b11, 16'h3800, 0, 0, "R7 type6 ignored");
    // R3 partial writes
    op(1, 2'b01, 16'h2000, 0, 0, "R3 low byte only");
    op(1, 2'b10, 16'h2400, 0, 0, "R3 high byte only");
    op(1, 2'b00, 16'h3400, 0, 0, "R3 no byte lanes");
    // R9 SCI inputs
    op(0, 2'b00, 16'h0000, 1, 0, "R9 set");
    op(0, 2'b00, 16'h0000, 0, 1, "R9 clear");
    op(0, 2'b00, 16'h0000, 1, 1, "R9 both set wins");
    // R10 collisions, including with a sleep request
    op(1, 2'b11, 16'h0000, 1, 0, "R10 write0 with set");
    op(1, 2'b11, 16'hFFFF, 0, 1, "R10 write1 with clear");
    op(1, 2'b11, 16'h2000, 1, 1, "R10 sleep write with both");
    // R11 hibType onto fixed codes
    @(negedge clk); hibType = 3'd0;
    op(1, 2'b11, 16'h2000, 0, 0, "R11 hibType0 type0 off only");
    @(negedge clk); hibType = 3'd1;
    op(1, 2'b11, 16'h2400, 0, 0, "R11 hibType1 type1 suspend only");
    @(negedge clk); hibType = 3'd7;
    op(1, 2'b11, 16'h3400, 0, 0, "R7 type5 no longer hibernate");
    op(1, 2'b11, 16'h3C00, 0, 0, "R6 type7 hibernate");
    // R12 back-to-back
    op(1, 2'b11, 16'h2000, 0, 0, "R12 back-to-back off 1");
    op(1, 2'b11, 16'h2000, 0, 0, "R12 back-to-back off 2");
    op(1, 2'b11, 16'h2400, 0, 0, "R12 back-to-back suspend");
    idle("R12 trailing idle");
    idle("R12 final idle");
    repeat (3) @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule